// File: doc/BRIEF.md
# Serial Channel Error Flag Unit

This unit keeps the error record for one serial channel. The channel can act as an asynchronous receiver, as a two-wire bus transmitter, or as a clocked-serial slave. The shift datapath sends single-cycle event strobes into the unit:

- end of an asynchronous frame, with the sampled stop level and both parity bits;
- the acknowledge sample of a two-wire write;
- storage of a received word;
- software reads and writes of the data register;
- the transmitter taking a buffered word;
- the start of a slave transfer.

From these strobes the unit derives three sticky error flags (framing, parity-or-missing-acknowledge, and overrun) and a buffer-occupied indication.

Software sees the flags in a status word. It removes a flag only by writing a 1 to the matching bit of a separate clear register. Writing the status register does nothing. The clear register always reads back as zero. If a channel has no framing detection, the parameter `HAS_FRAME` is set to 0, and the framing bit then stays at zero.

Top module: `serial_err_status`

## Requirements
- R1: After reset every status bit reads 0: framing flag, parity flag, overrun flag and buffer-occupied bit.
- R2: In asynchronous-receive mode (mode code 0), an end-of-frame strobe with the stop level sampled as 0 sets the framing flag (status bit 2).
- R3: When `HAS_FRAME` is 0, status bit 2 reads 0 under every stimulus.
- R4: In mode 0, an end-of-frame strobe whose received parity bit differs from the computed parity sets the parity flag (status bit 1).
- R5: In two-wire transmit mode (mode code 1), an acknowledge-sample strobe with the bus level at 1 (no acknowledge) sets the parity flag. A level of 0 leaves it unchanged.
- R6: With the receiver enabled, a word-stored strobe while the buffer is occupied and not read in that same cycle sets the overrun flag (status bit 0).
- R7: In slave mode (mode code 2), a transfer-start strobe with transmit active while the buffer is empty sets the overrun flag.
- R8: A software write of the data register while the buffer is occupied sets the overrun flag.
- R9: A clear-register write clears each flag whose data bit is 1 (bit 0 overrun, bit 1 parity, bit 2 framing) and leaves the flags whose bit is 0. A status-register write changes no flag.
- R10: When a set event and a clear of the same flag occur in one cycle, the flag ends up set.
- R11: The buffer-occupied bit (status bit 6) sets on a word-stored strobe or a data-register write. Without a new load, it clears on a data-register read or a transmitter take.
- R12: Reading with the clear register selected returns zero. All status bits other than 0, 1, 2 and 6 read 0.
- R13: Strobes that belong to another mode have no effect. An end-of-frame strobe acts only in mode 0, an acknowledge strobe only in mode 1, and a transfer-start strobe only in mode 2. Mode code 3 has none of these events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | Channel mode: 0 async receive, 1 two-wire transmit, 2 slave, 3 none |
| rx_en_i | input | 1 | Receiver enabled |
| frame_end_i | input | 1 | End-of-frame strobe (async receive) |
| stop_lvl_i | input | 1 | Sampled stop level at end of frame |
| par_rx_i | input | 1 | Received parity bit |
| par_calc_i | input | 1 | Parity computed over received data |
| ack_smp_i | input | 1 | Acknowledge sample strobe |
| ack_lvl_i | input | 1 | Bus level at acknowledge sample (1 = no acknowledge) |
| rx_store_i | input | 1 | Received word stored to data register |
| dr_rd_i | input | 1 | Software read of data register |
| dr_wr_i | input | 1 | Software write of data register |
| tx_take_i | input | 1 | Transmitter took the buffered word |
| xfer_start_i | input | 1 | Slave transfer must start |
| xfer_tx_i | input | 1 | Slave transfer includes transmit |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 status, 1 clear |
| wr_data_i | input | REG_W | Register write data |
| rd_sel_i | input | 1 | Read target: 0 status, 1 clear |
| rd_data_o | output | REG_W | Register read data |

## Verification
Every flag and the buffer-occupied bit are registered once. A strobe applied before a rising edge therefore shows in the status word right after that edge. The read path is combinational on the flip-flops and on the read select.

The bench drives all strobes on the falling edge and lets exactly one rising edge pass. It compares the status word at the next falling edge against a model that it steps from the requirements. It then flips the read select and compares again after a short settle, without another edge.

A second instance built without framing detection gets the same stimulus and is compared on every step.

// File: rtl/serr_pkg.sv
package serr_pkg;
    typedef enum logic [1:0] {
        MODE_ASYNC_RX = 2'd0,
        MODE_TWI_TX   = 2'd1,
        MODE_SLAVE    = 2'd2,
        MODE_NONE     = 2'd3
    } chan_mode_e;

    // flag index equals its status and clear bit position
    localparam int FLG_OVR   = 0;
    localparam int FLG_PAR   = 1;
    localparam int FLG_FRM   = 2;
    localparam int NUM_FLAGS = 3;
    localparam int BIT_BUF   = 6;
endpackage

// File: rtl/serr_event_dec.sv
module serr_event_dec
    import serr_pkg::*;
(
    input  logic [1:0]           mode_i,
    input  logic                 rx_en_i,
    input  logic                 frame_end_i,
    input  logic                 stop_lvl_i,
    input  logic                 par_rx_i,
    input  logic                 par_calc_i,
    input  logic                 ack_smp_i,
    input  logic                 ack_lvl_i,
    input  logic                 rx_store_i,
    input  logic                 dr_rd_i,
    input  logic                 dr_wr_i,
    input  logic                 xfer_start_i,
    input  logic                 xfer_tx_i,
    input  logic                 buf_full_i,
    output logic [NUM_FLAGS-1:0] set_o
);
    chan_mode_e mode;
    logic       ovr_rx, ovr_wr, ovr_slv;

    always_comb begin
        mode    = chan_mode_e'(mode_i);
        set_o   = '0;
        ovr_rx  = rx_en_i && rx_store_i && buf_full_i && !dr_rd_i;
        ovr_wr  = dr_wr_i && buf_full_i;
        ovr_slv = (mode == MODE_SLAVE) && xfer_start_i && xfer_tx_i && !buf_full_i;
        set_o[FLG_OVR] = ovr_rx || ovr_wr || ovr_slv;
        set_o[FLG_FRM] = (mode == MODE_ASYNC_RX) && frame_end_i && !stop_lvl_i;
        set_o[FLG_PAR] = ((mode == MODE_ASYNC_RX) && frame_end_i && (par_rx_i != par_calc_i))
                      || ((mode == MODE_TWI_TX) && ack_smp_i && ack_lvl_i);
    end
endmodule

// File: rtl/serr_sticky.sv
module serr_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    typedef struct packed {
        logic flag;
    } sticky_t;

    sticky_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) st_d.flag = 1'b0;
        if (set_i) st_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.flag;
endmodule

// File: rtl/serr_buf_track.sv
module serr_buf_track (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_store_i,
    input  logic dr_wr_i,
    input  logic dr_rd_i,
    input  logic tx_take_i,
    output logic full_o
);
    typedef struct packed {
        logic full;
    } buf_t;

    buf_t bs_d, bs_q;

    always_comb begin
        bs_d = bs_q;
        if (rx_store_i || dr_wr_i)     bs_d.full = 1'b1;
        else if (dr_rd_i || tx_take_i) bs_d.full = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bs_q <= '0;
        else        bs_q <= bs_d;
    end

    assign full_o = bs_q.full;
endmodule

// File: rtl/serial_err_status.sv
module serial_err_status
    import serr_pkg::*;
#(
    parameter bit HAS_FRAME = 1'b1,
    parameter int REG_W     = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode_i,
    input  logic             rx_en_i,
    input  logic             frame_end_i,
    input  logic             stop_lvl_i,
    input  logic             par_rx_i,
    input  logic             par_calc_i,
    input  logic             ack_smp_i,
    input  logic             ack_lvl_i,
    input  logic             rx_store_i,
    input  logic             dr_rd_i,
    input  logic             dr_wr_i,
    input  logic             tx_take_i,
    input  logic             xfer_start_i,
    input  logic             xfer_tx_i,
    input  logic             wr_en_i,
    input  logic             wr_sel_i,
    input  logic [REG_W-1:0] wr_data_i,
    input  logic             rd_sel_i,
    output logic [REG_W-1:0] rd_data_o
);
    localparam int STAT_MSB = BIT_BUF;

    logic [NUM_FLAGS-1:0] set_vec;
    logic [NUM_FLAGS-1:0] clr_vec;
    logic [NUM_FLAGS-1:0] flags;
    logic                 buf_full;
    logic [REG_W-1:0]     stat_word;
    logic                 unused_wdata;

    assign unused_wdata = ^wr_data_i[REG_W-1:NUM_FLAGS];

    serr_event_dec u_dec (
        .mode_i       (mode_i),
        .rx_en_i      (rx_en_i),
        .frame_end_i  (frame_end_i),
        .stop_lvl_i   (stop_lvl_i),
        .par_rx_i     (par_rx_i),
        .par_calc_i   (par_calc_i),
        .ack_smp_i    (ack_smp_i),
        .ack_lvl_i    (ack_lvl_i),
        .rx_store_i   (rx_store_i),
        .dr_rd_i      (dr_rd_i),
        .dr_wr_i      (dr_wr_i),
        .xfer_start_i (xfer_start_i),
        .xfer_tx_i    (xfer_tx_i),
        .buf_full_i   (buf_full),
        .set_o        (set_vec)
    );

    serr_buf_track u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_store_i (rx_store_i),
        .dr_wr_i    (dr_wr_i),
        .dr_rd_i    (dr_rd_i),
        .tx_take_i  (tx_take_i),
        .full_o     (buf_full)
    );

    // only the clear register decodes write data; status writes are dropped
    assign clr_vec = {NUM_FLAGS{wr_en_i && wr_sel_i}} & wr_data_i[NUM_FLAGS-1:0];

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
        if (i == FLG_FRM && !HAS_FRAME) begin : g_absent
            logic unused_ev;
            assign unused_ev = set_vec[i] ^ clr_vec[i];
            assign flags[i]  = 1'b0;
        end else begin : g_present
            serr_sticky u_flag (
                .clk    (clk),
                .rst_n  (rst_n),
                .set_i  (set_vec[i]),
                .clr_i  (clr_vec[i]),
                .flag_o (flags[i])
            );
        end
    end

    always_comb begin
        stat_word                     = '0;
        stat_word[NUM_FLAGS-1:0]      = flags;
        stat_word[STAT_MSB]           = buf_full;
        rd_data_o                     = rd_sel_i ? '0 : stat_word;
    end
endmodule

// File: rtl/serr_status_chk.sv
module serr_status_chk
    import serr_pkg::*;
#(
    parameter bit HAS_FRAME = 1'b1,
    parameter int REG_W     = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_en_i,
    input logic                 wr_sel_i,
    input logic [REG_W-1:0]     wr_data_i,
    input logic                 rd_sel_i,
    input logic [REG_W-1:0]     rd_data_o,
    input logic                 dr_wr_i,
    input logic                 buf_full,
    input logic [NUM_FLAGS-1:0] set_vec,
    input logic [NUM_FLAGS-1:0] flags
);
    logic clr_wr;
    assign clr_wr = wr_en_i && wr_sel_i;

    AST_PAR_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        set_vec[FLG_PAR] |=> flags[FLG_PAR]); // R4

    AST_OVR_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec[FLG_OVR] && clr_wr && wr_data_i[FLG_OVR]) |=> flags[FLG_OVR]); // R10

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[FLG_OVR] && !(clr_wr && wr_data_i[FLG_OVR])) |=> flags[FLG_OVR]); // R9

    AST_PAR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && wr_data_i[FLG_PAR] && !set_vec[FLG_PAR]) |=> !flags[FLG_PAR]); // R9

    AST_STAT_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !wr_sel_i && flags[FLG_PAR]) |=> flags[FLG_PAR]); // R9

    AST_WR_FULL_OVR: assert property (@(posedge clk) disable iff (!rst_n)
        (dr_wr_i && buf_full) |=> flags[FLG_OVR]); // R8

    AST_CLR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_sel_i |-> (rd_data_o == '0)); // R12

    AST_NO_FRAME_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        !HAS_FRAME |-> !flags[FLG_FRM]); // R3
endmodule

bind serial_err_status serr_status_chk #(
    .HAS_FRAME (HAS_FRAME),
    .REG_W     (REG_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .rd_sel_i  (rd_sel_i),
    .rd_data_o (rd_data_o),
    .dr_wr_i   (dr_wr_i),
    .buf_full  (buf_full),
    .set_vec   (set_vec),
    .flags     (flags)
);

// File: tb/serial_err_status_test.sv
`timescale 1ns/1ps
module serial_err_status_test;
    localparam int W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] mode = 2'd0;
    logic rx_en = 0, frame_end = 0, stop_lvl = 1, par_rx = 0, par_calc = 0;
    logic ack_smp = 0, ack_lvl = 0, rx_store = 0, dr_rd = 0, dr_wr = 0, tx_take = 0;
    logic xfer_start = 0, xfer_tx = 0, wr_en = 0, wr_sel = 0, rd_sel = 0;
    logic [W-1:0] wr_data = '0;
    logic [W-1:0] rd_a, rd_b;

    int total = 0;
    int bad = 0;
    logic e_ovr = 0, e_par = 0, e_frm = 0, e_buf = 0;

    always #2 clk = ~clk;

    serial_err_status #(.HAS_FRAME(1'b1), .REG_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .rx_en_i(rx_en),
        .frame_end_i(frame_end), .stop_lvl_i(stop_lvl), .par_rx_i(par_rx),
        .par_calc_i(par_calc), .ack_smp_i(ack_smp), .ack_lvl_i(ack_lvl),
        .rx_store_i(rx_store), .dr_rd_i(dr_rd), .dr_wr_i(dr_wr), .tx_take_i(tx_take),
        .xfer_start_i(xfer_start), .xfer_tx_i(xfer_tx), .wr_en_i(wr_en),
        .wr_sel_i(wr_sel), .wr_data_i(wr_data), .rd_sel_i(rd_sel), .rd_data_o(rd_a));

    serial_err_status #(.HAS_FRAME(1'b0), .REG_W(W)) uut_nf (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .rx_en_i(rx_en),
        .frame_end_i(frame_end), .stop_lvl_i(stop_lvl), .par_rx_i(par_rx),
        .par_calc_i(par_calc), .ack_smp_i(ack_smp), .ack_lvl_i(ack_lvl),
        .rx_store_i(rx_store), .dr_rd_i(dr_rd), .dr_wr_i(dr_wr), .tx_take_i(tx_take),
        .xfer_start_i(xfer_start), .xfer_tx_i(xfer_tx), .wr_en_i(wr_en),
        .wr_sel_i(wr_sel), .wr_data_i(wr_data), .rd_sel_i(rd_sel), .rd_data_o(rd_b));

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [W-1:0] exp_word(input logic with_frm);
        logic [W-1:0] v;
        v = '0;
        v[0] = e_ovr;
        v[1] = e_par;
        v[2] = e_frm & with_frm;
        v[6] = e_buf;
        return v;
    endfunction

    task automatic idle_inputs();
        mode = 2'd0; rx_en = 0; frame_end = 0; stop_lvl = 1; par_rx = 0; par_calc = 0;
        ack_smp = 0; ack_lvl = 0; rx_store = 0; dr_rd = 0; dr_wr = 0; tx_take = 0;
        xfer_start = 0; xfer_tx = 0; wr_en = 0; wr_sel = 0; wr_data = '0; rd_sel = 0;
    endtask

    // advance one edge with the inputs already driven, then compare
    task automatic step(input string tag);
        logic s_ovr, s_par, s_frm;
        logic [2:0] clr;
        s_frm = (mode == 2'd0) && frame_end && !stop_lvl;
        s_par = ((mode == 2'd0) && frame_end && (par_rx != par_calc))
             || ((mode == 2'd1) && ack_smp && ack_lvl);
        s_ovr = (rx_en && rx_store && e_buf && !dr_rd) || (dr_wr && e_buf)
             || ((mode == 2'd2) && xfer_start && xfer_tx && !e_buf);
        clr = (wr_en && wr_sel) ? wr_data[2:0] : 3'b000;
        e_ovr = s_ovr | (e_ovr & ~clr[0]);
        e_par = s_par | (e_par & ~clr[1]);
        e_frm = s_frm | (e_frm & ~clr[2]);
        if (rx_store || dr_wr)     e_buf = 1'b1;
        else if (dr_rd || tx_take) e_buf = 1'b0;
        @(posedge clk);
        @(negedge clk);
        idle_inputs();
        #0.1;
        check(tag, rd_a, exp_word(1'b1));
        check("R3", rd_b, exp_word(1'b0));
        rd_sel = 1'b1;
        #0.1;
        check("R12", rd_a, '0);
        check("R12", rd_b, '0);
        rd_sel = 1'b0;
    endtask

    task automatic clear_all();
        wr_en = 1; wr_sel = 1; wr_data = 16'h0007; dr_rd = 1;
        step("R9");
    endtask

    task automatic load_buf();
        rx_store = 1;
        step("R11");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle_inputs();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #0.1;
        check("R1", rd_a, '0);
        check("R1", rd_b, '0);

        // end-of-frame sweep over mode, stop level and both parity bits
        for (int m = 0; m < 4; m++)
            for (int sb = 0; sb < 2; sb++)
                for (int pr = 0; pr < 2; pr++)
                    for (int pc = 0; pc < 2; pc++) begin
                        clear_all();
                        mode = 2'(m); frame_end = 1; stop_lvl = 1'(sb);
                        par_rx = 1'(pr); par_calc = 1'(pc);
                        step(m != 0 ? "R13" : (sb == 0 ? "R2" : "R4"));
                    end

        // acknowledge sample sweep
        for (int m = 0; m < 4; m++)
            for (int a = 0; a < 2; a++) begin
                clear_all();
                mode = 2'(m); ack_smp = 1; ack_lvl = 1'(a);
                step(m == 1 ? "R5" : "R13");
            end

        // receive overrun: enable x buffer state x same-cycle read
        for (int en = 0; en < 2; en++)
            for (int pre = 0; pre < 2; pre++)
                for (int rd = 0; rd < 2; rd++) begin
                    clear_all();
                    if (pre != 0) load_buf();
                    rx_en = 1'(en); rx_store = 1; dr_rd = 1'(rd);
                    step("R6");
                end

        // buffer indication: read, take, load-with-read
        clear_all();
        load_buf();
        tx_take = 1;
        step("R11");
        load_buf();
        dr_rd = 1;
        step("R11");
        dr_wr = 1;
        step("R11");
        rx_store = 1; dr_rd = 1;
        step("R11");

        // slave transfer start sweep
        for (int m = 0; m < 4; m++)
            for (int tx = 0; tx < 2; tx++)
                for (int pre = 0; pre < 2; pre++) begin
                    clear_all();
                    if (pre != 0) load_buf();
                    mode = 2'(m); xfer_start = 1; xfer_tx = 1'(tx);
                    step(m == 2 ? "R7" : "R13");
                end

        // data-register write sweep
        for (int pre = 0; pre < 2; pre++)
            for (int tk = 0; tk < 2; tk++) begin
                clear_all();
                if (pre != 0) load_buf();
                dr_wr = 1; tx_take = 1'(tk);
                step("R8");
            end

        // clear patterns on all-set flags, after an ignored status write
        for (int pat = 0; pat < 8; pat++) begin
            clear_all();
            load_buf();
            mode = 2'd0; frame_end = 1; stop_lvl = 0; par_rx = 1; par_calc = 0; dr_wr = 1;
            step("R9");
            wr_en = 1; wr_sel = 0; wr_data = 16'hFFFF;
            step("R9");
            wr_en = 1; wr_sel = 1; wr_data = 16'(pat);
            step("R9");
        end

        // set and clear in the same cycle
        clear_all();
        load_buf();
        mode = 2'd0; frame_end = 1; stop_lvl = 0; par_rx = 0; par_calc = 1; dr_wr = 1;
        wr_en = 1; wr_sel = 1; wr_data = 16'h0007;
        step("R10");
        mode = 2'd1; ack_smp = 1; ack_lvl = 1;
        wr_en = 1; wr_sel = 1; wr_data = 16'h0002;
        step("R10");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule